// File: doc/BRIEF.md
# Wiper and Stored-Setting Register Controller

This block carries out commands that a serial-bus front end has already framed and decoded. It holds one volatile wiper register and four retained setting registers of the same width, and it produces a one-hot tap-select vector that drives the switch array of a resistor ladder. The front end passes in the read/write bit, the three-bit opcode and the two-bit register selector when an instruction byte is accepted. It also passes in each assembled data word and a strobe when the bus stop condition is seen.

Wiper loads take effect at once and never make the block busy. Writes into a setting register wait for the stop strobe. They are gated by an active-low protect input, and a committed write holds `busy` high for a parameterised number of clock cycles, the stand-in for a slow retained-memory write cycle. While `busy` is high the front end is expected to refuse the bus, and the block ignores every strobe. A power-on reset restores the wiper from setting register 0. A soft reset clears the wiper and the busy timer, and neither reset alters the setting registers.

Top module: `wiper_store_ctrl`

## Requirements
- R1: A command is recognised from {cmd_rw, cmd_opc} as follows: read wiper 1/100, write wiper 0/101, read setting 1/101, write setting 0/110, setting-to-wiper 1/110, wiper-to-setting 0/111. Any other combination changes nothing and returns no read data.
- R2: A read command (wiper, or the setting register chosen by cmd_sel) raises rd_valid for exactly one cycle, in the cycle after cmd_valid, with rd_data holding the selected register's value.
- R3: After a write-wiper command, a wr_valid strobe loads wr_data into the wiper in the next cycle, and busy stays low.
- R4: A setting-to-wiper command copies the selected setting register into the wiper in the cycle after cmd_valid, and busy stays low.
- R5: A write-setting command stores the last wr_data into the selected setting register only on bus_stop. Busy is low before the stop, and a committed write holds busy high for exactly BUSY_CYCLES cycles starting the cycle after the stop.
- R6: A wiper-to-setting command stores the wiper value into the selected setting register on bus_stop, with the same busy timing as R5.
- R7: If wp_n is low when bus_stop arrives for a setting write or wiper-to-setting transfer, no setting register changes and busy stays low. Wiper loads are not affected by wp_n.
- R8: While busy is high, cmd_valid, wr_valid and bus_stop are ignored: the wiper and setting registers keep their values and no read data is returned.
- R9: In the first cycle after por_n is released (with rst_n high), the wiper equals setting register 0. The setting registers keep their contents across por_n.
- R10: While rst_n is low, the wiper is 0 and busy is low. The setting registers keep their contents across rst_n.
- R11: tap_sel has exactly one bit set, at the index equal to the wiper value: bit 0 for wiper 0x000 and bit 1023 for wiper 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low soft reset |
| por_n | input | 1 | Synchronous active-low power-on reset; release triggers recall |
| cmd_valid | input | 1 | Instruction byte accepted by the front end |
| cmd_rw | input | 1 | Read/write bit from the address byte |
| cmd_opc | input | 3 | Instruction opcode |
| cmd_sel | input | 2 | Setting register selector |
| wr_valid | input | 1 | Assembled data word available |
| wr_data | input | 10 | Data word from the bus |
| bus_stop | input | 1 | Stop condition seen on the bus |
| wp_n | input | 1 | Active-low protect for setting-register writes |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 10 | Read data for the front end |
| busy | output | 1 | Retained write cycle in progress |
| wiper | output | 10 | Current wiper register value |
| tap_sel | output | 1024 | One-hot tap select decoded from the wiper |

## Verification
The bench measures the exact length of the busy window. A timer that is off by one, or that never starts, gives a different count. It issues write-setting and transfer commands with wp_n low, which catches a design that commits or goes busy while protected, and it tries wiper loads during busy, which catches a design that drops the ignore gate. It pulses both resets and reads the setting registers back, which exposes a design that clears retained storage or skips the recall. It also drives illegal opcode pairs and the two extreme wiper values to catch decode slips and a tap decoder that is off at its ends.

// File: rtl/wsc_pkg.sv
// Shared types for the wiper/setting controller.
// Assumes: opcode values are fixed by the bus command set.
package wsc_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_WIPER,
        OP_WR_WIPER,
        OP_RD_SET,
        OP_WR_SET,
        OP_SET2WIPER,
        OP_WIPER2SET
    } op_e;
endpackage

// File: rtl/wsc_cmd_decode.sv
// Maps the read/write bit and the 3-bit opcode onto an internal operation.
// Assumes: inputs are meaningful only while the caller's valid is high.
module wsc_cmd_decode
    import wsc_pkg::*;
(
    input  logic       rw,
    input  logic [2:0] opc,
    output op_e        op
);
    // Pure lookup from {rw, opcode} to operation; unknown pairs map to OP_NONE.
    always_comb begin
        case ({rw, opc})
            4'b1100: op = OP_RD_WIPER;
            4'b0101: op = OP_WR_WIPER;
            4'b1101: op = OP_RD_SET;
            4'b0110: op = OP_WR_SET;
            4'b1110: op = OP_SET2WIPER;
            4'b0111: op = OP_WIPER2SET;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/wsc_busy_timer.sv
// Down-counter that models the retained write cycle.
// Assumes: start is never raised while busy is already high.
module wsc_busy_timer #(
    parameter int CYCLES = 1250000
) (
    input  logic clk,
    input  logic run_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, count down to zero, clear on reset.
    always_ff @(posedge clk) begin
        if (!run_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_busy_starts_R5: assert property (@(posedge clk) disable iff (!run_n)
        start |=> busy);
    assert_no_spurious_busy_R7: assert property (@(posedge clk) disable iff (!run_n)
        (!busy && !start) |=> !busy);
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!run_n)
        start |-> !busy);
endmodule

// File: rtl/wsc_tap_decode.sv
// Turns a binary wiper value into a one-hot tap-select vector.
// Assumes: TAPS equals 2**VAL_W so every code selects a tap.
module wsc_tap_decode #(
    parameter int VAL_W = 10,
    localparam int TAPS = 1 << VAL_W
) (
    input  logic [VAL_W-1:0] value,
    output logic [TAPS-1:0]  tap
);
    // One comparator per tap.
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap[i] = (value == VAL_W'(i));
    end
endmodule

// File: rtl/wiper_store_ctrl.sv
// Executes decoded bus commands against a volatile wiper register and a
// bank of retained setting registers; drives a one-hot tap select.
// Assumes: the front end handles framing/acks and refuses the bus while busy.
module wiper_store_ctrl
    import wsc_pkg::*;
#(
    parameter int VAL_W       = 10,
    parameter int NUM_SET     = 4,
    parameter int BUSY_CYCLES = 1250000,
    localparam int SEL_W      = $clog2(NUM_SET),
    localparam int TAPS       = 1 << VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             cmd_valid,
    input  logic             cmd_rw,
    input  logic [2:0]       cmd_opc,
    input  logic [SEL_W-1:0] cmd_sel,
    input  logic             wr_valid,
    input  logic [VAL_W-1:0] wr_data,
    input  logic             bus_stop,
    input  logic             wp_n,
    output logic             rd_valid,
    output logic [VAL_W-1:0] rd_data,
    output logic             busy,
    output logic [VAL_W-1:0] wiper,
    output logic [TAPS-1:0]  tap_sel
);
    logic             run_n;
    op_e              op_d;
    op_e              cur_op_q;
    logic [SEL_W-1:0] cur_sel_q;
    logic [VAL_W-1:0] pend_q;
    logic             have_q;
    logic             recall_q;
    logic [VAL_W-1:0] wiper_q;
    logic [VAL_W-1:0] set_q [NUM_SET];
    logic             take_cmd;
    logic             take_wr;
    logic             set_write;
    logic             commit;
    logic [VAL_W-1:0] commit_val;

    assign run_n     = rst_n && por_n;
    assign take_cmd  = cmd_valid && !busy;
    assign take_wr   = wr_valid && !busy;
    assign set_write = (cur_op_q == OP_WIPER2SET) ||
                       (cur_op_q == OP_WR_SET && have_q);
    assign commit    = bus_stop && !busy && wp_n && set_write;
    assign commit_val = (cur_op_q == OP_WIPER2SET) ? wiper_q : pend_q;

    wsc_cmd_decode u_dec (
        .rw  (cmd_rw),
        .opc (cmd_opc),
        .op  (op_d)
    );

    wsc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .run_n (run_n),
        .start (commit),
        .busy  (busy)
    );

    wsc_tap_decode #(.VAL_W(VAL_W)) u_tap (
        .value (wiper_q),
        .tap   (tap_sel)
    );

    // Track the command in progress and the data word it carries.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            cur_op_q  <= OP_NONE;
            cur_sel_q <= '0;
            pend_q    <= '0;
            have_q    <= 1'b0;
        end else if (take_cmd) begin
            cur_op_q  <= op_d;
            cur_sel_q <= cmd_sel;
            have_q    <= 1'b0;
        end else if (bus_stop && !busy) begin
            cur_op_q  <= OP_NONE;
            have_q    <= 1'b0;
        end else if (take_wr && cur_op_q == OP_WR_SET) begin
            pend_q    <= wr_data;
            have_q    <= 1'b1;
        end
    end

    // Remember that a power-on reset happened until the recall is done.
    always_ff @(posedge clk) begin
        if (!por_n)
            recall_q <= 1'b1;
        else if (rst_n)
            recall_q <= 1'b0;
    end

    // Wiper register: recall, transfer from a setting, or direct load.
    always_ff @(posedge clk) begin
        if (!run_n)
            wiper_q <= '0;
        else if (recall_q)
            wiper_q <= set_q[0];
        else if (take_cmd && op_d == OP_SET2WIPER)
            wiper_q <= set_q[cmd_sel];
        else if (take_wr && cur_op_q == OP_WR_WIPER)
            wiper_q <= wr_data;
    end

    // Retained setting registers: no reset, written only on a committed stop.
    always_ff @(posedge clk) begin
        if (run_n && commit)
            set_q[cur_sel_q] <= commit_val;
    end

    // Read return path, one cycle after the instruction is taken.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take_cmd && (op_d == OP_RD_WIPER || op_d == OP_RD_SET);
            if (take_cmd)
                rd_data <= (op_d == OP_RD_WIPER) ? wiper_q : set_q[cmd_sel];
        end
    end

    assign wiper = wiper_q;

    assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!run_n)
        (cmd_valid && !busy && cmd_rw && (cmd_opc == 3'b100 || cmd_opc == 3'b101)) |=> rd_valid);
    assert_no_read_on_write_R1: assert property (@(posedge clk) disable iff (!run_n)
        (cmd_valid && !cmd_rw) |=> !rd_valid);
    assert_wiper_frozen_R8: assert property (@(posedge clk) disable iff (!run_n)
        (busy && !recall_q) |=> $stable(wiper_q));
    assert_protect_R7: assert property (@(posedge clk) disable iff (!run_n)
        (bus_stop && !busy && !wp_n) |=> !busy && set_q[$past(cur_sel_q)] == $past(set_q[cur_sel_q]));
    assert_recall_R9: assert property (@(posedge clk) disable iff (!run_n)
        recall_q |=> wiper_q == $past(set_q[0]));
    assert_tap_onehot_R11: assert property (@(posedge clk) disable iff (!run_n)
        $countones(tap_sel) == 1 && tap_sel[wiper_q]);
    assert_soft_reset_R10: assert property (@(posedge clk)
        (!rst_n && por_n) |=> wiper_q == '0 && !busy);
endmodule

// File: tb/sim_wiper_store_ctrl.sv
module sim_wiper_store_ctrl;
    localparam int W    = 10;
    localparam int NB   = 20;
    localparam int TAPS = 1 << W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0, por_n = 1'b0;
    logic           cmd_valid = 1'b0, cmd_rw = 1'b0;
    logic [2:0]     cmd_opc = '0;
    logic [1:0]     cmd_sel = '0;
    logic           wr_valid = 1'b0, bus_stop = 1'b0, wp_n = 1'b1;
    logic [W-1:0]   wr_data = '0;
    logic           rd_valid, busy;
    logic [W-1:0]   rd_data, wiper;
    logic [TAPS-1:0] tap_sel;

    int nchk = 0, nbad = 0;
    logic [W-1:0] mset [4];
    logic [W-1:0] mwip;
    bit done = 0;

    always #4 clk = ~clk;

    wiper_store_ctrl #(.BUSY_CYCLES(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .cmd_valid(cmd_valid),
        .cmd_rw(cmd_rw), .cmd_opc(cmd_opc), .cmd_sel(cmd_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .bus_stop(bus_stop), .wp_n(wp_n),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .wiper(wiper),
        .tap_sel(tap_sel)
    );

    function automatic int exp_busy(input logic prot_ok);
        return prot_ok ? NB : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic rw, input logic [2:0] opc, input logic [1:0] sel);
        cmd_valid = 1'b1; cmd_rw = rw; cmd_opc = opc; cmd_sel = sel;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_data(input logic [W-1:0] v);
        wr_valid = 1'b1; wr_data = v;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic send_stop(output int nbusy);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        nbusy = 0;
        while (busy && nbusy < 10 * NB) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic chk_wiper(input string req);
        send_cmd(1'b1, 3'b100, 2'd0);
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " wiper read"}, int'(rd_data), int'(mwip));
        check({req, " wiper port"}, int'(wiper), int'(mwip));
        check("R11 tap bit", int'(tap_sel[mwip]), 1);
        check("R11 tap count", $countones(tap_sel), 1);
    endtask

    task automatic chk_set(input string req, input int s);
        send_cmd(1'b1, 3'b101, 2'(s));
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " setting read"}, int'(rd_data), int'(mset[s]));
        @(negedge clk);
        check({req, " rd_valid one cycle"}, int'(rd_valid), 0);
    endtask

    task automatic do_wr_wiper(input logic [W-1:0] v);
        int nb;
        send_cmd(1'b0, 3'b101, 2'd0);
        send_data(v);
        mwip = v;
        check("R3 wiper loaded", int'(wiper), int'(v));
        check("R3 no busy", int'(busy), 0);
        send_stop(nb);
        check("R3 no busy after stop", nb, 0);
    endtask

    task automatic do_wr_set(input int s, input logic [W-1:0] v, input logic prot);
        int nb;
        wp_n = prot;
        send_cmd(1'b0, 3'b110, 2'(s));
        send_data(v);
        check("R5 no busy before stop", int'(busy), 0);
        send_stop(nb);
        check(prot ? "R5 busy length" : "R7 no busy when protected", nb, exp_busy(prot));
        if (prot) mset[s] = v;
        wp_n = 1'b1;
    endtask

    task automatic do_w2s(input int s, input logic prot);
        int nb;
        wp_n = prot;
        send_cmd(1'b0, 3'b111, 2'(s));
        send_stop(nb);
        check(prot ? "R6 busy length" : "R7 no busy when protected", nb, exp_busy(prot));
        if (prot) mset[s] = mwip;
        wp_n = 1'b1;
    endtask

    task automatic do_s2w(input int s);
        int nb;
        send_cmd(1'b1, 3'b110, 2'(s));
        mwip = mset[s];
        check("R4 wiper from setting", int'(wiper), int'(mwip));
        check("R4 no busy", int'(busy), 0);
        send_stop(nb);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin : main
        int nb;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R10 reset busy", int'(busy), 0);
        check("R10 reset rd_valid", int'(rd_valid), 0);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // Known contents everywhere.
        for (int s = 0; s < 4; s++) do_wr_set(s, W'(100 * s + 7), 1'b1);
        do_wr_wiper(10'h155);
        chk_wiper("R2");
        for (int s = 0; s < 4; s++) chk_set("R5", s);

        // Extreme taps.
        do_wr_wiper(10'h000);
        check("R11 low end", int'(tap_sel[0]), 1);
        do_wr_wiper(10'h3FF);
        check("R11 high end", int'(tap_sel[TAPS-1]), 1);
        chk_wiper("R11");

        // Transfers.
        do_s2w(2);
        chk_wiper("R4");
        do_wr_wiper(10'h2A1);
        do_w2s(1, 1'b1);
        chk_set("R6", 1);

        // Protection.
        do_wr_set(3, 10'h0F0, 1'b0);
        chk_set("R7", 3);
        do_w2s(0, 1'b0);
        chk_set("R7", 0);
        wp_n = 1'b0;
        do_wr_wiper(10'h0AB);
        wp_n = 1'b1;
        chk_wiper("R7 wiper unaffected");

        // Illegal pairs.
        send_cmd(1'b1, 3'b111, 2'd0);
        check("R1 illegal read", int'(rd_valid), 0);
        send_cmd(1'b0, 3'b100, 2'd1);
        send_data(10'h3C3);
        send_stop(nb);
        check("R1 illegal no busy", nb, 0);
        chk_wiper("R1");
        chk_set("R1", 1);

        // Strobes during busy are ignored.
        wp_n = 1'b1;
        send_cmd(1'b0, 3'b110, 2'd2);
        send_data(10'h111);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        mset[2] = 10'h111;
        send_cmd(1'b0, 3'b101, 2'd0);
        send_data(10'h222);
        check("R8 wiper held", int'(wiper), int'(mwip));
        send_cmd(1'b1, 3'b100, 2'd0);
        check("R8 no read while busy", int'(rd_valid), 0);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        while (busy) @(negedge clk);
        chk_wiper("R8");
        chk_set("R8", 2);

        // Soft reset keeps settings.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 wiper cleared", int'(wiper), 0);
        check("R10 busy cleared", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mwip = '0;
        chk_wiper("R10");
        for (int s = 0; s < 4; s++) chk_set("R10", s);

        // Power-on recall.
        do_wr_set(0, 10'h2E5, 1'b1);
        do_wr_wiper(10'h013);
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        mwip = mset[0];
        check("R9 recall", int'(wiper), int'(mwip));
        chk_wiper("R9");
        for (int s = 0; s < 4; s++) chk_set("R9", s);

        // Random mix.
        for (int i = 0; i < 160; i++) begin
            int kind = int'($urandom_range(0, 4));
            int s = int'($urandom_range(0, 3));
            logic [W-1:0] v = W'($urandom);
            logic pr = ($urandom_range(0, 4) != 0);
            case (kind)
                0: do_wr_wiper(v);
                1: do_wr_set(s, v, pr);
                2: do_s2w(s);
                3: do_w2s(s, pr);
                default: chk_set("R2", s);
            endcase
            chk_wiper("R1 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule